// File: doc/BRIEF.md
# Program-Ordered Load/Store Issue Queue

This block holds in-flight memory instructions in a circular buffer so that their position always reflects program order. Each cycle a decoder may append up to four new loads or stores at the tail; each entry waits until its source operand is available, which it learns either at allocation or from a broadcast producer tag. Once ready, entries compete for a single issue slot toward the address and cache pipeline, with the entry nearest the head winning.

An issued entry is not released. It stays allocated and flagged as issued while the memory side works on it. A response names the entry and says whether the access completed or failed. A failure (cache miss, conflict, dependency) returns the entry to the pool of issue candidates, so the same entry is sent again later. Completed entries leave the queue only from the head, when the commit logic signals graduation, and never past an entry that has not completed. A flush empties the queue and returns both pointers to index zero.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt_o` equals DEPTH (16) and `iss_vld_o` is 0.
- R2: When `alloc_cnt_i` is n (1 to 4) and accepted, slots 0..n-1 of the allocation vectors are written to entries `tail_idx_o`, `tail_idx_o`+1, ... (modulo 16), slot s occupying bits [s*W +: W] of each vector; on the next cycle `free_cnt_o` drops by n and `tail_idx_o` advances by n.
- R3: An entry is ready when its `alloc_rdy_i` bit was 1, or when `wake_vld_i` is 1 with `wake_tag_i` equal to its stored tag; this includes a wakeup in the same cycle as the entry's allocation. A tag mismatch leaves the entry waiting.
- R4: At most one entry issues per cycle: `iss_vld_o`, `iss_idx_o` and `iss_pay_o` present it combinationally from registered state; at the next clock edge it is marked issued, is not presented again unless it fails, and stays allocated (`free_cnt_o` unchanged).
- R5: Among ready, unissued, incomplete entries, the one at the smallest distance from the head (counting forward with wrap-around) is issued.
- R6: A response with `resp_vld_i`=1 for an issued entry sets it complete when `resp_fail_i`=0, or clears its issued flag when `resp_fail_i`=1, making it eligible to issue again from the same index.
- R7: With `grad_cnt_i` = g (0 to 4), the queue frees the k leading entries from the head that are complete, where k is at most g and counting stops at the first incomplete entry; `free_cnt_o` rises by k on the next cycle.
- R8: An allocation request larger than the current `free_cnt_o`, or larger than 4, is ignored as a whole: no entry is written and `tail_idx_o` does not move. A request equal to the free count is accepted.
- R9: `flush_i`=1 forces `iss_vld_o` to 0 in that cycle and on the next cycle leaves the queue empty with head and tail at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all entries and reset pointers |
| alloc_cnt_i | input | 3 | Number of instructions appended this cycle (0 to 4) |
| alloc_rdy_i | input | 4 | Per slot: operand already available |
| alloc_tag_i | input | 24 | Per slot: 6-bit producer tag |
| alloc_pay_i | input | 32 | Per slot: 8-bit opaque instruction payload |
| tail_idx_o | output | 4 | Entry index that slot 0 of the next allocation receives |
| free_cnt_o | output | 5 | Number of unallocated entries |
| wake_vld_i | input | 1 | Producer tag broadcast valid |
| wake_tag_i | input | 6 | Producer tag being broadcast |
| iss_vld_o | output | 1 | An entry is issued this cycle |
| iss_idx_o | output | 4 | Index of the issued entry |
| iss_pay_o | output | 8 | Payload of the issued entry |
| resp_vld_i | input | 1 | Memory-side response valid |
| resp_idx_i | input | 4 | Entry the response refers to |
| resp_fail_i | input | 1 | 1: access failed, reissue; 0: access completed |
| grad_cnt_i | input | 3 | Maximum number of head entries to graduate (0 to 4) |

## Verification
The collision that matters most is a tag broadcast landing in the same cycle an instruction waiting on that tag is being appended; the bench drives both in one cycle, alongside a second new entry with a different tag, and expects the matching entry to be presented for issue on the very next cycle while the other stays silent. A second overlap is issue against the wrap point: entries are placed on both sides of index 15/0 and the late wakeup of index 15 must beat ready entries at lower indices. Graduation is driven with an incomplete entry inside the requested window to confirm it stops early.

// File: rtl/ldst_queue_pkg.sv
package ldst_queue_pkg;
  typedef struct packed {
    logic vld;
    logic rdy;
    logic iss;
    logic done;
  } ent_flags_t;

  localparam ent_flags_t FLAGS_EMPTY = '0;
endpackage

// File: rtl/ldst_queue_pick.sv
// Head-relative priority pick: nearest candidate to head wins.
module ldst_queue_pick #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] pos;

  always_comb begin
    found_o = 1'b0;
    idx_o   = head_i;
    pos     = head_i;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = head_i + IDX_W'(k);
      if (cand_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/ldst_queue_retire.sv
// Counts leading complete entries from head, capped by request.
module ldst_queue_retire #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int GRAD_W = 4,
  parameter int GCNT_W = $clog2(GRAD_W + 1)
) (
  input  logic [DEPTH-1:0]  done_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [GCNT_W-1:0] grad_cnt_i,
  output logic [GCNT_W-1:0] ret_cnt_o
);
  logic             run;
  logic [IDX_W-1:0] pos;

  always_comb begin
    run       = 1'b1;
    ret_cnt_o = '0;
    pos       = head_i;
    for (int k = 0; k < GRAD_W; k++) begin
      pos = head_i + IDX_W'(k);
      if (run && (GCNT_W'(k) < grad_cnt_i) && done_i[pos])
        ret_cnt_o = ret_cnt_o + GCNT_W'(1);
      else
        run = 1'b0;
    end
  end
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue
  import ldst_queue_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ENQ_W  = 4,
  parameter int GRAD_W = 4,
  parameter int TAG_W  = 6,
  parameter int PAY_W  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int NCNT_W = $clog2(ENQ_W + 1),
  localparam int GCNT_W = $clog2(GRAD_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [NCNT_W-1:0]      alloc_cnt_i,
  input  logic [ENQ_W-1:0]       alloc_rdy_i,
  input  logic [ENQ_W*TAG_W-1:0] alloc_tag_i,
  input  logic [ENQ_W*PAY_W-1:0] alloc_pay_i,
  output logic [IDX_W-1:0]       tail_idx_o,
  output logic [CNT_W-1:0]       free_cnt_o,
  input  logic                   wake_vld_i,
  input  logic [TAG_W-1:0]       wake_tag_i,
  output logic                   iss_vld_o,
  output logic [IDX_W-1:0]       iss_idx_o,
  output logic [PAY_W-1:0]       iss_pay_o,
  input  logic                   resp_vld_i,
  input  logic [IDX_W-1:0]       resp_idx_i,
  input  logic                   resp_fail_i,
  input  logic [GCNT_W-1:0]      grad_cnt_i
);
  ent_flags_t       flags_q [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [PAY_W-1:0] pay_q   [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DEPTH-1:0]  cand, done_vec;
  logic              found;
  logic [IDX_W-1:0]  pick_idx;
  logic [GCNT_W-1:0] ret_cnt;
  logic              accept;

  logic [TAG_W-1:0] slot_tag [ENQ_W];
  logic [PAY_W-1:0] slot_pay [ENQ_W];
  logic [ENQ_W-1:0] slot_rdy, slot_en;
  logic [IDX_W-1:0] slot_pos [ENQ_W];

  assign free_cnt_o = CNT_W'(DEPTH) - cnt_q;
  assign tail_idx_o = tail_q;
  assign accept = !flush_i && (alloc_cnt_i != '0)
               && (alloc_cnt_i <= NCNT_W'(ENQ_W))
               && (CNT_W'(alloc_cnt_i) <= free_cnt_o);

  for (genvar s = 0; s < ENQ_W; s++) begin : g_slot
    assign slot_tag[s] = alloc_tag_i[s*TAG_W +: TAG_W];
    assign slot_pay[s] = alloc_pay_i[s*PAY_W +: PAY_W];
    // same-cycle wakeup bypass
    assign slot_rdy[s] = alloc_rdy_i[s] | (wake_vld_i && (slot_tag[s] == wake_tag_i));
    assign slot_en[s]  = accept && (NCNT_W'(s) < alloc_cnt_i);
    assign slot_pos[s] = tail_q + IDX_W'(s);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign cand[i]     = flags_q[i].vld & flags_q[i].rdy & ~flags_q[i].iss & ~flags_q[i].done;
    assign done_vec[i] = flags_q[i].vld & flags_q[i].done;
  end

  ldst_queue_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .cand_i  (cand),
    .head_i  (head_q),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  ldst_queue_retire #(.DEPTH(DEPTH), .IDX_W(IDX_W), .GRAD_W(GRAD_W), .GCNT_W(GCNT_W)) u_retire (
    .done_i     (done_vec),
    .head_i     (head_q),
    .grad_cnt_i (grad_cnt_i),
    .ret_cnt_o  (ret_cnt)
  );

  assign iss_vld_o = found & ~flush_i;
  assign iss_idx_o = pick_idx;
  assign iss_pay_o = pay_q[pick_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= FLAGS_EMPTY;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= FLAGS_EMPTY;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wake_vld_i && flags_q[i].vld && (tag_q[i] == wake_tag_i))
          flags_q[i].rdy <= 1'b1;
      if (resp_vld_i && flags_q[resp_idx_i].vld && flags_q[resp_idx_i].iss
          && !flags_q[resp_idx_i].done) begin
        if (resp_fail_i) flags_q[resp_idx_i].iss  <= 1'b0;
        else             flags_q[resp_idx_i].done <= 1'b1;
      end
      if (iss_vld_o) flags_q[pick_idx].iss <= 1'b1;
      for (int k = 0; k < GRAD_W; k++)
        if (GCNT_W'(k) < ret_cnt) flags_q[head_q + IDX_W'(k)] <= FLAGS_EMPTY;
      for (int s = 0; s < ENQ_W; s++)
        if (slot_en[s])
          flags_q[slot_pos[s]] <= '{vld: 1'b1, rdy: slot_rdy[s], iss: 1'b0, done: 1'b0};
      head_q <= head_q + IDX_W'(ret_cnt);
      tail_q <= tail_q + (accept ? IDX_W'(alloc_cnt_i) : '0);
      cnt_q  <= cnt_q + (accept ? CNT_W'(alloc_cnt_i) : '0) - CNT_W'(ret_cnt);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int s = 0; s < ENQ_W; s++)
      if (slot_en[s]) begin
        tag_q[slot_pos[s]] <= slot_tag[s];
        pay_q[slot_pos[s]] <= slot_pay[s];
      end
  end
endmodule

// File: rtl/ldst_queue_chk.sv
module ldst_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int NCNT_W = 3,
  parameter int GCNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic [NCNT_W-1:0] alloc_cnt_i,
  input logic [GCNT_W-1:0] grad_cnt_i,
  input logic              resp_vld_i,
  input logic [CNT_W-1:0]  free_cnt_o,
  input logic              iss_vld_o,
  input logic [IDX_W-1:0]  iss_idx_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  a_r9_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !iss_vld_o);

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (free_cnt_o == FULL));

  a_r8_over_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && (CNT_W'(alloc_cnt_i) > free_cnt_o)) |=> (free_cnt_o >= $past(free_cnt_o)));

  a_r2_alloc_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && (alloc_cnt_i != '0) && (alloc_cnt_i <= NCNT_W'(4))
     && (CNT_W'(alloc_cnt_i) <= free_cnt_o) && (grad_cnt_i == '0))
    |=> (free_cnt_o == $past(free_cnt_o) - CNT_W'($past(alloc_cnt_i))));

  a_r4_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o == FULL) |-> !iss_vld_o);

  a_r4_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_o && !resp_vld_i && !flush_i) |=> !(iss_vld_o && (iss_idx_o == $past(iss_idx_o))));

  a_r7_no_grad_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grad_cnt_i == '0) && !flush_i) |=> (free_cnt_o <= $past(free_cnt_o)));
endmodule

bind ldst_queue ldst_queue_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .NCNT_W(NCNT_W), .GCNT_W(GCNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .alloc_cnt_i (alloc_cnt_i),
  .grad_cnt_i  (grad_cnt_i),
  .resp_vld_i  (resp_vld_i),
  .free_cnt_o  (free_cnt_o),
  .iss_vld_o   (iss_vld_o),
  .iss_idx_o   (iss_idx_o)
);

// File: tb/ldst_queue_test.sv
module ldst_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush;
  logic [2:0]  alloc_cnt;
  logic [3:0]  alloc_rdy;
  logic [23:0] alloc_tag;
  logic [31:0] alloc_pay;
  logic [3:0]  tail_idx;
  logic [4:0]  free_cnt;
  logic        wake_vld;
  logic [5:0]  wake_tag;
  logic        iss_vld;
  logic [3:0]  iss_idx;
  logic [7:0]  iss_pay;
  logic        resp_vld;
  logic [3:0]  resp_idx;
  logic        resp_fail;
  logic [2:0]  grad_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ldst_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .alloc_cnt_i(alloc_cnt), .alloc_rdy_i(alloc_rdy), .alloc_tag_i(alloc_tag),
    .alloc_pay_i(alloc_pay), .tail_idx_o(tail_idx), .free_cnt_o(free_cnt),
    .wake_vld_i(wake_vld), .wake_tag_i(wake_tag),
    .iss_vld_o(iss_vld), .iss_idx_o(iss_idx), .iss_pay_o(iss_pay),
    .resp_vld_i(resp_vld), .resp_idx_i(resp_idx), .resp_fail_i(resp_fail),
    .grad_cnt_i(grad_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; alloc_cnt = 0; alloc_rdy = 0; alloc_tag = 0; alloc_pay = 0;
    wake_vld = 0; wake_tag = 0; resp_vld = 0; resp_idx = 0; resp_fail = 0; grad_cnt = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic set_alloc(input int n, input logic [3:0] rdy,
                           input int t0, input int t1, input int t2, input int t3, input int pb);
    alloc_cnt = 3'(n);
    alloc_rdy = rdy;
    alloc_tag = {6'(t3), 6'(t2), 6'(t1), 6'(t0)};
    alloc_pay = {8'(pb + 3), 8'(pb + 2), 8'(pb + 1), 8'(pb)};
  endtask

  task automatic resp(input int idx, input bit fail);
    resp_vld = 1; resp_idx = 4'(idx); resp_fail = fail;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "free after reset", free_cnt, 16);
    chk("R1", "issue after reset", iss_vld, 0);
  endtask

  task automatic t_fill_issue();
    set_alloc(4, 4'hF, 0, 0, 0, 0, 'hA0); step();
    chk("R2", "free after 4 allocs", free_cnt, 12);
    chk("R2", "tail after 4 allocs", tail_idx, 4);
    chk("R4", "first issue valid", iss_vld, 1);
    chk("R4", "first issue index", iss_idx, 0);
    chk("R2", "slot0 payload", iss_pay, 'hA0);
    step(); chk("R4", "second issue index", iss_idx, 1);
    step(); chk("R4", "third issue index", iss_idx, 2);
    chk("R2", "slot2 payload", iss_pay, 'hA2);
    step(); chk("R4", "fourth issue index", iss_idx, 3);
    step(); chk("R4", "no repeat issue", iss_vld, 0);
    chk("R4", "issued entries stay allocated", free_cnt, 12);
  endtask

  task automatic t_fail_grad();
    resp(2, 1); step();
    chk("R6", "reissue valid after fail", iss_vld, 1);
    chk("R6", "reissue same index", iss_idx, 2);
    step(); chk("R6", "no issue after reissue", iss_vld, 0);
    resp(0, 0); step();
    resp(1, 0); step();
    resp(3, 0); step();
    grad_cnt = 1; step();
    chk("R7", "graduation capped at request", free_cnt, 13);
    grad_cnt = 4; step();
    chk("R7", "graduation stops at incomplete", free_cnt, 14);
    resp(2, 0); step();
    grad_cnt = 4; step();
    chk("R7", "remaining graduate", free_cnt, 16);
    chk("R7", "empty after graduation", iss_vld, 0);
  endtask

  task automatic t_wake();
    set_alloc(2, 4'h0, 7, 9, 0, 0, 'h50); step();
    chk("R3", "waiting entries do not issue", iss_vld, 0);
    chk("R2", "tail continues after wrap of head", tail_idx, 6);
    wake_vld = 1; wake_tag = 9; step();
    chk("R3", "woken entry issues", iss_idx, 5);
    chk("R3", "woken entry valid", iss_vld, 1);
    step(); chk("R3", "other tag still waiting", iss_vld, 0);
    wake_vld = 1; wake_tag = 7; step();
    chk("R3", "second wakeup issues", iss_idx, 4);
    set_alloc(2, 4'h0, 11, 12, 0, 0, 'h66);
    wake_vld = 1; wake_tag = 11; step();
    chk("R3", "same-cycle wake bypass valid", iss_vld, 1);
    chk("R3", "same-cycle wake bypass index", iss_idx, 6);
    chk("R3", "same-cycle wake payload", iss_pay, 'h66);
    step(); chk("R3", "mismatched tag not woken", iss_vld, 0);
  endtask

  task automatic t_flush();
    flush = 1; step();
    chk("R9", "free after flush", free_cnt, 16);
    chk("R9", "tail after flush", tail_idx, 0);
    set_alloc(1, 4'h1, 0, 0, 0, 0, 'h11); step();
    chk("R9", "pointers reset", iss_idx, 0);
    chk("R9", "post-flush payload", iss_pay, 'h11);
    flush = 1; #1;
    chk("R9", "issue masked during flush", iss_vld, 0);
    step();
    chk("R9", "flush discards unissued", free_cnt, 16);
  endtask

  task automatic t_priority();
    set_alloc(3, 4'b0110, 3, 0, 0, 0, 'h30); step();
    chk("R5", "oldest ready first", iss_idx, 1);
    step(); chk("R5", "next ready", iss_idx, 2);
    step(); chk("R5", "none ready", iss_vld, 0);
    wake_vld = 1; wake_tag = 3; step();
    chk("R5", "head entry after wake", iss_idx, 0);
    flush = 1; step();
  endtask

  task automatic t_wrap();
    for (int b = 0; b < 3; b++) begin
      set_alloc(4, 4'hF, 0, 0, 0, 0, 0); step();
      repeat (4) step();
    end
    for (int k = 0; k < 12; k++) begin
      resp(k, 0); step();
    end
    repeat (3) begin grad_cnt = 4; step(); end
    chk("R7", "drained to index 12", free_cnt, 16);
    chk("R7", "tail at 12", tail_idx, 12);
    set_alloc(4, 4'h0, 20, 20, 20, 21, 'hC0); step();
    chk("R3", "wrap batch waiting", iss_vld, 0);
    set_alloc(4, 4'hF, 0, 0, 0, 0, 'hB0); step();
    chk("R2", "tail wrapped", tail_idx, 4);
    chk("R5", "only wrapped entry ready", iss_idx, 0);
    wake_vld = 1; wake_tag = 21; step();
    chk("R5", "index 15 beats 1 across wrap", iss_idx, 15);
    chk("R5", "index 15 payload", iss_pay, 'hC3);
  endtask

  task automatic t_overflow();
    chk("R8", "free before fill", free_cnt, 8);
    set_alloc(4, 4'hF, 0, 0, 0, 0, 0); step();
    chk("R8", "free after fill", free_cnt, 4);
    set_alloc(4, 4'hF, 0, 0, 0, 0, 0); step();
    chk("R8", "exact fit accepted", free_cnt, 0);
    chk("R8", "tail after exact fit", tail_idx, 12);
    set_alloc(1, 4'hF, 0, 0, 0, 0, 0); step();
    chk("R8", "overflow ignored free", free_cnt, 0);
    chk("R8", "overflow ignored tail", tail_idx, 12);
    flush = 1; step();
    set_alloc(5, 4'hF, 0, 0, 0, 0, 0); step();
    chk("R8", "count above 4 ignored", free_cnt, 16);
  endtask

  initial begin
    t_reset();
    t_fill_issue();
    t_fail_grad();
    t_wake();
    t_flush();
    t_priority();
    t_wrap();
    t_overflow();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule